// File: doc/BRIEF.md
# Adaptive-to-Escape Virtual Channel Class Selector

This block sits at one input port of a two-dimensional mesh router and decides, each cycle, where the packet waiting at the head of that port may go next. A packet that has not given up on adaptive routing may take any minimal output direction on any free virtual channel of the adaptive pool. When two minimal directions both have a free channel, a rotating pointer chooses between them, so neither direction wins every tie.

A packet gives up on adaptive routing in one of two ways. The first is that the router asserts the blocked input. The second is that no adaptive channel is free on any of its minimal directions for a set number of consecutive cycles. After that, the packet takes the single escape channel of each port and follows a strict X-then-Y route. The decision is one-way: the outgoing mode bit is written back into the header, and once that bit is set the packet is never offered an adaptive channel again.

A packet that has reached its destination is always sent to the local port, whatever its mode. Arbitration between several input ports that compete for the same output is handled outside this block.

Top module: `escvc_selector`

## Requirements
- R1: After reset, with no request present, `grant_valid` and `mode_out` are 0. The rotating pointer starts at East, so the first adaptive tie between East and North goes to East.
- R2: When both `x_dir` and `y_dir` are 2'b00 (the destination), a request is granted at once on port 0 (local), and `grant_class` equals the effective mode.
- R3: In adaptive mode, a grant names a minimal direction with at least one free adaptive VC, sets `grant_class` to 0, and sets `grant_vc` to the lowest free VC index of that direction. Port codes are 1 East, 2 West, 3 North and 4 South. On `x_dir`, 2'b01 means East and 2'b10 means West. On `y_dir`, 2'b01 means North and 2'b10 means South. In `adp_free`, group d (NAVC bits starting at d*NAVC) holds direction d, with d = 0 East, 1 West, 2 North, 3 South.
- R4: Adaptive ties are broken by a rotating pointer over the order East, West, North, South. After an adaptive grant on direction d, the search starts at direction d+1 (mod 4).
- R5: A request that finds no free adaptive VC on any minimal direction for BLOCK_LIMIT consecutive cycles is handled in escape mode from the next cycle on.
- R6: `blk_in` puts the request into escape mode in the same cycle. If that request is not granted, escape mode persists for it.
- R7: In escape mode the route is X before Y. The port is East or West while `x_dir` is non-zero, and North or South otherwise. A grant is given only if that port's bit in `esc_free` (bit d, same direction order as R3) is set, with `grant_class` 1 and `grant_vc` 0. Adaptive availability is ignored.
- R8: With `mode_in` set, no grant has `grant_class` 0 unless it is a local grant, and `mode_out` is 1 while the request is present.
- R9: A grant, or a cycle without a request, clears the starvation count and the fallback state, so the next request starts in adaptive mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Head packet requests an output |
| mode_in | input | 1 | Header mode bit, 1 = already in escape mode |
| blk_in | input | 1 | Blocked indication, forces escape mode |
| x_dir | input | 2 | X offset sign: 00 none, 01 East, 10 West |
| y_dir | input | 2 | Y offset sign: 00 none, 01 North, 10 South |
| adp_free | input | 4*NAVC | Free adaptive VCs, NAVC bits per direction |
| esc_free | input | 4 | Escape VC free, one bit per direction |
| grant_valid | output | 1 | A grant is given this cycle |
| grant_port | output | 3 | Granted port, 0 local, 1 to 4 as in R3 |
| grant_class | output | 1 | 0 adaptive pool, 1 escape |
| grant_vc | output | VCW | VC index within the granted class |
| mode_out | output | 1 | Mode bit to write back into the header |

## Verification
The bench builds the selector with NAVC=2 and BLOCK_LIMIT=3. The short limit lets a run of starved cycles reach the fallback point within a few cycles, and it lets random traffic with sparse free-channel masks cross that point often. Two channels per direction are enough to check that the lowest free index is chosen when only the upper channel is free. Directed sequences cover the exact fallback cycle, pointer rotation across consecutive ties, and an escape route held back while adaptive channels are free.

// File: rtl/escvc_pkg.sv
package escvc_pkg;
   localparam int NDIR = 4;
   typedef enum logic [2:0] {
      PORT_LOCAL = 3'd0,
      PORT_EAST  = 3'd1,
      PORT_WEST  = 3'd2,
      PORT_NORTH = 3'd3,
      PORT_SOUTH = 3'd4
   } port_e;
   localparam logic [1:0] DIR_NONE = 2'b00;
   localparam logic [1:0] DIR_POS  = 2'b01;
   localparam logic [1:0] DIR_NEG  = 2'b10;
endpackage

// File: rtl/escvc_dor_route.sv
module escvc_dor_route
   import escvc_pkg::*;
(
   input  logic [1:0] x_dir,
   input  logic [1:0] y_dir,
   input  logic [3:0] esc_free,
   output port_e      dor_port,
   output logic       dor_ok
);
   logic [1:0] dir_idx;

   always_comb begin
      if (x_dir != DIR_NONE) begin
         dir_idx = (x_dir == DIR_POS) ? 2'd0 : 2'd1;
      end else begin
         dir_idx = (y_dir == DIR_POS) ? 2'd2 : 2'd3;
      end
      dor_port = port_e'({1'b0, dir_idx} + 3'd1);
      dor_ok   = esc_free[dir_idx];
   end
endmodule

// File: rtl/escvc_adp_pick.sv
module escvc_adp_pick
   import escvc_pkg::*;
#(
   parameter int NAVC = 2,
   localparam int VCW = (NAVC > 1) ? $clog2(NAVC) : 1
)(
   input  logic               clk,
   input  logic               rst_n,
   input  logic [1:0]         x_dir,
   input  logic [1:0]         y_dir,
   input  logic [4*NAVC-1:0]  adp_free,
   input  logic               advance,
   output logic               any_free,
   output port_e              pick_port,
   output logic [VCW-1:0]     pick_vc
);
   logic [NDIR-1:0] cand;
   logic [NDIR-1:0] dfree;
   logic [VCW-1:0]  dvc [NDIR];
   logic [1:0]      rr_q;
   logic [1:0]      sel;

   assign cand[0] = (x_dir == DIR_POS);
   assign cand[1] = (x_dir == DIR_NEG);
   assign cand[2] = (y_dir == DIR_POS);
   assign cand[3] = (y_dir == DIR_NEG);

   for (genvar d = 0; d < NDIR; d++) begin : g_dir
      logic [NAVC-1:0] bits;
      assign bits     = adp_free[d*NAVC +: NAVC];
      assign dfree[d] = cand[d] & (|bits);
      always_comb begin
         dvc[d] = '0;
         for (int v = NAVC - 1; v >= 0; v--) begin
            if (bits[v]) dvc[d] = VCW'(v);
         end
      end
   end

   always_comb begin
      logic [1:0] idx;
      any_free = 1'b0;
      sel      = 2'd0;
      for (int k = 0; k < NDIR; k++) begin
         idx = rr_q + 2'(k);
         if (!any_free && dfree[idx]) begin
            any_free = 1'b1;
            sel      = idx;
         end
      end
      pick_port = port_e'({1'b0, sel} + 3'd1);
      pick_vc   = dvc[sel];
   end

   always_ff @(posedge clk) begin
      if (!rst_n)       rr_q <= 2'd0;
      else if (advance) rr_q <= sel + 2'd1;
   end

   a_r3_pick_minimal: assert property (@(posedge clk) disable iff (!rst_n)
      any_free |-> (cand[sel] && adp_free[sel*NAVC + int'(pick_vc)]));
   a_r4_pointer_steps: assert property (@(posedge clk) disable iff (!rst_n)
      advance |=> (rr_q == $past(sel) + 2'd1));
endmodule

// File: rtl/escvc_block_timer.sv
module escvc_block_timer #(
   parameter int BLOCK_LIMIT = 4,
   localparam int CW = $clog2(BLOCK_LIMIT + 1)
)(
   input  logic clk,
   input  logic rst_n,
   input  logic clear,
   input  logic set_now,
   input  logic starved,
   output logic drop_q
);
   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n || clear) begin
         cnt_q  <= '0;
         drop_q <= 1'b0;
      end else if (set_now) begin
         drop_q <= 1'b1;
      end else if (starved) begin
         if (cnt_q == CW'(BLOCK_LIMIT - 1)) drop_q <= 1'b1;
         else                               cnt_q  <= cnt_q + 1'b1;
      end else begin
         cnt_q <= '0;
      end
   end

   a_r5_drop_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(drop_q) |-> $past(starved || set_now));
   a_r9_clear_resets: assert property (@(posedge clk) disable iff (!rst_n)
      clear |=> !drop_q);
endmodule

// File: rtl/escvc_selector.sv
module escvc_selector
   import escvc_pkg::*;
#(
   parameter int NAVC        = 2,
   parameter int BLOCK_LIMIT = 4,
   localparam int VCW = (NAVC > 1) ? $clog2(NAVC) : 1
)(
   input  logic               clk,
   input  logic               rst_n,
   input  logic               req_valid,
   input  logic               mode_in,
   input  logic               blk_in,
   input  logic [1:0]         x_dir,
   input  logic [1:0]         y_dir,
   input  logic [4*NAVC-1:0]  adp_free,
   input  logic [3:0]         esc_free,
   output logic               grant_valid,
   output logic [2:0]         grant_port,
   output logic               grant_class,
   output logic [VCW-1:0]     grant_vc,
   output logic               mode_out
);
   if (NAVC < 1) begin : g_bad_navc
      $error("NAVC must be at least 1");
   end
   if (BLOCK_LIMIT < 1) begin : g_bad_limit
      $error("BLOCK_LIMIT must be at least 1");
   end

   logic           at_dest, eff_esc, drop_q;
   logic           any_free, dor_ok;
   port_e          pick_port, dor_port;
   logic [VCW-1:0] pick_vc;
   logic           advance, starved;

   assign at_dest = (x_dir == DIR_NONE) && (y_dir == DIR_NONE);
   assign eff_esc = mode_in | drop_q | blk_in;
   assign advance = req_valid & ~at_dest & ~eff_esc & any_free;
   assign starved = req_valid & ~at_dest & ~eff_esc & ~any_free;

   escvc_dor_route u_dor (
      .x_dir(x_dir), .y_dir(y_dir), .esc_free(esc_free),
      .dor_port(dor_port), .dor_ok(dor_ok)
   );

   escvc_adp_pick #(.NAVC(NAVC)) u_adp (
      .clk(clk), .rst_n(rst_n), .x_dir(x_dir), .y_dir(y_dir),
      .adp_free(adp_free), .advance(advance), .any_free(any_free),
      .pick_port(pick_port), .pick_vc(pick_vc)
   );

   escvc_block_timer #(.BLOCK_LIMIT(BLOCK_LIMIT)) u_tmr (
      .clk(clk), .rst_n(rst_n),
      .clear(~req_valid | grant_valid),
      .set_now(req_valid & blk_in & ~grant_valid),
      .starved(starved), .drop_q(drop_q)
   );

   always_comb begin
      grant_valid = 1'b0;
      grant_port  = PORT_LOCAL;
      grant_class = 1'b0;
      grant_vc    = '0;
      if (req_valid) begin
         if (at_dest) begin
            grant_valid = 1'b1;
            grant_class = eff_esc;
         end else if (eff_esc) begin
            grant_valid = dor_ok;
            grant_port  = dor_ok ? dor_port : PORT_LOCAL;
            grant_class = dor_ok;
         end else if (any_free) begin
            grant_valid = 1'b1;
            grant_port  = pick_port;
            grant_vc    = pick_vc;
         end
      end
   end

   assign mode_out = req_valid & eff_esc;

   a_r2_local_at_dest: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && x_dir == 2'b00 && y_dir == 2'b00) |->
         (grant_valid && grant_port == 3'd0));
   a_r8_sticky_mode: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && mode_in && grant_valid && grant_port != 3'd0) |-> grant_class);
   a_r7_x_first: assert property (@(posedge clk) disable iff (!rst_n)
      (grant_valid && grant_class && x_dir != 2'b00) |->
         (grant_port == 3'd1 || grant_port == 3'd2));
   a_r6_blocked_escapes: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && blk_in && grant_valid && grant_port != 3'd0) |-> grant_class);
endmodule

// File: tb/sim_escvc_selector.sv
module sim_escvc_selector;
   localparam int PERIOD = 10;
   localparam int NAVC   = 2;
   localparam int LIMIT  = 3;
   localparam int VCW    = (NAVC > 1) ? $clog2(NAVC) : 1;

   logic clk = 1'b0, rst_n = 1'b0;
   logic req_valid = 0, mode_in = 0, blk_in = 0;
   logic [1:0] x_dir = 0, y_dir = 0;
   logic [4*NAVC-1:0] adp_free = '0;
   logic [3:0] esc_free = '0;
   logic grant_valid, grant_class, mode_out;
   logic [2:0] grant_port;
   logic [VCW-1:0] grant_vc;

   int errors = 0, checks = 0;
   int m_rr = 0, m_cnt = 0;
   bit m_drop = 0;

   always #(PERIOD/2) clk = ~clk;

   escvc_selector #(.NAVC(NAVC), .BLOCK_LIMIT(LIMIT)) u0 (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .mode_in(mode_in),
      .blk_in(blk_in), .x_dir(x_dir), .y_dir(y_dir), .adp_free(adp_free),
      .esc_free(esc_free), .grant_valid(grant_valid), .grant_port(grant_port),
      .grant_class(grant_class), .grant_vc(grant_vc), .mode_out(mode_out)
   );

   task automatic chk(string tag, string what, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
      end
   endtask

   function automatic int dir_of(logic [1:0] xd, logic [1:0] yd);
      if (xd != 0) return (xd == 2'b01) ? 0 : 1;
      return (yd == 2'b01) ? 2 : 3;
   endfunction

   task automatic step(string tag, bit rq, bit mi, bit bk, logic [1:0] xd,
                       logic [1:0] yd, logic [4*NAVC-1:0] ad, logic [3:0] es);
      bit dest, eff, gv, cls, anyf, starve;
      int port, vc, sel;
      bit [3:0] cand, fr;
      @(negedge clk);
      req_valid = rq; mode_in = mi; blk_in = bk; x_dir = xd; y_dir = yd;
      adp_free = ad; esc_free = es;
      #1;
      dest = (xd == 0) && (yd == 0);
      eff  = mi | m_drop | bk;
      gv = 0; cls = 0; port = 0; vc = 0; sel = 0; anyf = 0;
      cand = {yd == 2'b10, yd == 2'b01, xd == 2'b10, xd == 2'b01};
      for (int d = 0; d < 4; d++) fr[d] = cand[d] && (ad[d*NAVC +: NAVC] != 0);
      for (int k = 0; k < 4; k++) begin
         if (!anyf && fr[(m_rr + k) % 4]) begin anyf = 1; sel = (m_rr + k) % 4; end
      end
      if (rq) begin
         if (dest) begin gv = 1; cls = eff; end
         else if (eff) begin
            port = dir_of(xd, yd) + 1; gv = es[port-1]; cls = 1;
         end else if (anyf) begin
            gv = 1; port = sel + 1;
            for (int v = NAVC - 1; v >= 0; v--) if (ad[sel*NAVC + v]) vc = v;
         end
      end
      chk(tag, "grant_valid", grant_valid, gv);
      chk(tag, "mode_out", mode_out, rq & eff);
      if (gv) begin
         chk(tag, "grant_port", grant_port, port);
         chk(tag, "grant_class", grant_class, cls);
         chk(tag, "grant_vc", grant_vc, vc);
      end
      starve = rq && !dest && !eff && !anyf;
      if (rq && gv && !dest && !eff) m_rr = (sel + 1) % 4;
      if (!rq || gv) begin m_cnt = 0; m_drop = 0; end
      else if (bk) m_drop = 1;
      else if (starve) begin
         if (m_cnt == LIMIT - 1) m_drop = 1; else m_cnt++;
      end else m_cnt = 0;
   endtask

   initial begin
      #(PERIOD * 150000);
      errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      void'($urandom(32'd1234));
      repeat (3) @(posedge clk);
      @(negedge clk); rst_n = 1'b1;
      step("R1_idle", 0, 0, 0, 2'b00, 2'b00, '0, '0);
      // R1 reset pointer: East beats North on first tie; then R4 rotation
      step("R1_tie", 1, 0, 0, 2'b01, 2'b01, 4'b0011 | (4'b0011 << 4), '0);
      step("R4_rot", 1, 0, 0, 2'b01, 2'b01, 4'b0011 | (4'b0011 << 4), '0);
      step("R4_rot", 1, 0, 0, 2'b10, 2'b10, '1, '0);
      step("R4_rot", 1, 0, 0, 2'b10, 2'b10, '1, '0);
      // R3 lowest free VC: only VC1 of West free
      step("R3_vc", 1, 0, 0, 2'b10, 2'b00, 8'b0000_1000, '1);
      // R2 destination, in either mode
      step("R2_dest", 1, 0, 0, 2'b00, 2'b00, '0, '0);
      step("R2_dest", 1, 1, 0, 2'b00, 2'b00, '0, '0);
      // R5 starvation then escape; R7 escape held until its VC is free
      step("R5_wait", 0, 0, 0, 2'b00, 2'b00, '0, '0);
      for (int i = 0; i < LIMIT; i++) step("R5_starve", 1, 0, 0, 2'b01, 2'b10, '0, 4'b0000);
      step("R7_hold", 1, 0, 0, 2'b01, 2'b10, '1, 4'b1000);
      step("R7_xfirst", 1, 0, 0, 2'b01, 2'b10, '1, 4'b1001);
      // R9 next packet starts adaptive again
      step("R9_fresh", 1, 0, 0, 2'b00, 2'b01, '1, '1);
      // R6 blocked indication escapes immediately and sticks
      step("R6_blk", 1, 0, 1, 2'b00, 2'b10, '1, 4'b0000);
      step("R6_stick", 1, 0, 0, 2'b00, 2'b10, '1, 4'b1000);
      // R8 sticky header mode ignores adaptive VCs
      step("R8_sticky", 1, 1, 0, 2'b10, 2'b01, '1, 4'b0010);
      step("R8_sticky", 1, 1, 0, 2'b00, 2'b01, '1, 4'b0000);
      step("R9_idle", 0, 0, 0, 2'b00, 2'b00, '0, '0);
      for (int i = 0; i < 3000; i++) begin
         logic [1:0] xd, yd;
         logic [4*NAVC-1:0] ad;
         xd = 2'($urandom % 3);
         yd = 2'($urandom % 3);
         ad = (($urandom % 3) == 0) ? (4*NAVC)'($urandom) : '0;
         step("R3_R5_R7_rand", ($urandom % 8) != 0, ($urandom % 10) == 0,
              ($urandom % 12) == 0, xd, yd, ad, 4'($urandom));
      end
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule